// File: doc/BRIEF.md
# SPI Status Flag Interrupt Unit

This block sits beside the transfer engine and the two FIFOs of an SPI controller. It receives their raw level flags, which describe completion, readiness, fill state, error conditions and a missing address setting, and shows them unchanged through a read-only live view. Each 0-to-1 transition of a flag is latched into a cause register. A mask register selects which causes may drive the single registered interrupt line.

Interrupts come from edges only. A flag that is already high when its mask bit is set raises no interrupt. Software therefore checks the live view first, and after that it unmasks the flag and waits for the next edge. Software acknowledges a cause by writing ones to the cause register. A simple register port carries the accesses. A write completes in the cycle it is presented. A read is presented with `reg_rd`, and its data returns one cycle later, qualified by `reg_rvalid`. The port never stalls, so it has no back-pressure.

Register selection (`reg_addr`): 0 is the live view (read-only), 1 is the cause register (write-1-to-clear), 2 is the mask register (read/write), and 3 reads zero. Writes to addresses 0 and 3 are dropped.

Top module: `spi_irq_status_unit`

## Requirements
- R1: A read of address 0 returns the live flags in bits 12:0, sampled at the read cycle, and zero above them. The bit order is: 0 transfer done, 1 transfer ready, 2 read-FIFO ready, 3 write-FIFO ready, 4 read-FIFO empty, 5 read-FIFO full, 6 write-FIFO empty, 7 write-FIFO full, 8 read-FIFO underflow, 9 read-FIFO overflow, 10 write-FIFO underflow, 11 write-FIFO overflow, 12 address not configured. The value does not depend on the cause or mask contents.
- R2: When a flag is low in one cycle and high in the next, its cause bit (same position) is set at the following clock edge. A read of address 1 issued one cycle after the rise returns that bit.
- R3: A flag that stays high sets no new cause after its cause bit is cleared. Unmasking such a flag leaves `irq` low.
- R4: Writing address 1 clears each cause bit whose write-data bit is 1 and leaves bits written 0 unchanged. Writing all ones clears every cause.
- R5: If a flag rises in the same cycle as a clear of its cause bit, the bit is set after that edge.
- R6: The mask register is written and read at address 2. It holds 13 bits, and bits 31:13 read zero. Writes to addresses 0 and 3 change neither the mask nor the causes, and a read of address 3 returns zero.
- R7: `irq` is a register. In each cycle it equals the OR of (cause AND mask) from the previous cycle, so it rises two edges after the flag rise that set the cause.
- R8: While the mask is zero, `irq` is low whatever the cause contents.
- R9: After reset the cause and mask registers are zero and `irq` is low. Flags that are already high while reset is asserted set no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_lvl | input | 13 | Raw level flags from the FIFOs and transfer engine |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 1 | Registered interrupt line |

## Verification
Some rules are checked by assertions on every cycle. These are: a held flag never produces a rise, every rise sets its cause even when a clear hits the same bit, cleared bits drop, no cause bit appears without a rise, a zero mask forces `irq` low, an enabled cause raises `irq`, and writes to other addresses leave the mask unchanged. Other behaviour can only be shown by the bench scenarios. These include the mapping of flags to bit positions in the live view, the read latency and address decode, the exact two-edge delay from a flag rise to `irq`, and a flag held high through reset. The bench also shows that unmasking an already-high flag stays silent until the next edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int FLAG_CNT = 13;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LEVEL = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // flag positions within the level view
  localparam int F_XFER_DONE   = 0;
  localparam int F_XFER_RDY    = 1;
  localparam int F_RX_RDY      = 2;
  localparam int F_TX_RDY      = 3;
  localparam int F_RX_EMPTY    = 4;
  localparam int F_RX_FULL     = 5;
  localparam int F_TX_EMPTY    = 6;
  localparam int F_TX_FULL     = 7;
  localparam int F_RX_UNDER    = 8;
  localparam int F_RX_OVER     = 9;
  localparam int F_TX_UNDER    = 10;
  localparam int F_TX_OVER     = 11;
  localparam int F_NO_ADDR     = 12;
endpackage

// File: rtl/sirq_edge_detect.sv
module sirq_edge_detect #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // history resets high: flags asserted through reset produce no edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R3: a flag already high in the previous cycle never counts as a rise
  p_held_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_o & $past(lvl_i)) == '0));
endmodule

// File: rtl/sirq_cause_bank.sv
module sirq_cause_bank #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)         cause_q[b] <= 1'b0;
      else if (rise_i[b]) cause_q[b] <= 1'b1;   // new edge beats a clear
      else if (clr_i[b])  cause_q[b] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  // R2 / R5: every rise is latched, even against a simultaneous clear
  p_rise_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((cause_o & $past(rise_i)) == $past(rise_i)));

  // R4: cleared bits without a competing rise drop
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~rise_i) != '0) |=> ((cause_o & $past(clr_i & ~rise_i)) == '0));

  // R3: no cause bit appears without a rise
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/sirq_line.sv
module sirq_line #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(cause_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_irq_status_unit.sv
module spi_irq_status_unit
  import spi_irq_pkg::*;
#(
  parameter int NUM_FLAGS = FLAG_CNT,
  parameter int DATA_W    = REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] status_lvl,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_rvalid,
  output logic                 irq
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] rise;
  logic [NUM_FLAGS-1:0] clr;
  logic [NUM_FLAGS-1:0] cause;
  logic [NUM_FLAGS-1:0] mask_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 rvalid_q;
  logic                 sel_cause;
  logic                 sel_mask;
  logic                 unused_wdata_hi;

  assign sel_cause       = (reg_addr == SEL_CAUSE);
  assign sel_mask        = (reg_addr == SEL_MASK);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_FLAGS];
  assign clr             = (reg_wr && sel_cause) ? reg_wdata[NUM_FLAGS-1:0] : '0;

  sirq_edge_detect #(.W(NUM_FLAGS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (status_lvl),
    .rise_o (rise)
  );

  sirq_cause_bank #(.W(NUM_FLAGS)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .clr_i   (clr),
    .cause_o (cause)
  );

  sirq_line #(.W(NUM_FLAGS)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_i (cause),
    .mask_i  (mask_q),
    .irq_o   (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                mask_q <= '0;
    else if (reg_wr && sel_mask) mask_q <= reg_wdata[NUM_FLAGS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) begin
        unique case (reg_addr)
          SEL_LEVEL: rdata_q <= {{PAD_W{1'b0}}, status_lvl};
          SEL_CAUSE: rdata_q <= {{PAD_W{1'b0}}, cause};
          SEL_MASK:  rdata_q <= {{PAD_W{1'b0}}, mask_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  // R8: a zero mask keeps the line low in the next cycle
  p_mask_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);

  // R7: an enabled cause raises the line one cycle later
  p_enabled_cause_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & mask_q) != '0) |=> irq);

  // R6: only a write at the mask address changes the mask
  p_mask_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel_mask) |=> $stable(mask_q));
endmodule

// File: tb/sim_spi_irq_status_unit.sv
module sim_spi_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] status_lvl = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  spi_irq_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .status_lvl(status_lvl),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq(irq)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // driver: issue a read and push its expected value to the scoreboard
  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_tests++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  // monitor: compare returned read data against the scoreboard
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R9: rx empty and tx empty held high through reset
    status_lvl = 13'h050;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    rd(2'd1, 32'h0, "R9 cause zero after reset");
    rd(2'd2, 32'h0, "R9 mask zero after reset");
    chk_irq(1'b0, "R9 irq low after reset");
    rd(2'd0, 32'h050, "R1 live view");

    // R2: transfer done rises
    status_lvl = 13'h051;
    tick();
    rd(2'd1, 32'h001, "R2 cause on rise");
    chk_irq(1'b0, "R8 masked cause silent");

    // R4: zeros keep, ones clear
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h001, "R4 zero write keeps");
    wr(2'd1, 32'h001);
    rd(2'd1, 32'h0, "R4 one write clears");

    // R3: held flag, then unmask everything
    tick(3);
    rd(2'd1, 32'h0, "R3 held flag no cause");
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0000_1FFF, "R6 mask width");
    tick(2);
    chk_irq(1'b0, "R3 unmask high flag silent");

    // R7: address-not-configured rises; irq two edges later
    status_lvl = 13'h1051;
    tick();
    chk_irq(1'b0, "R7 irq not yet");
    tick();
    chk_irq(1'b1, "R7 irq after two edges");

    // R8: zero mask silences
    wr(2'd2, 32'h0);
    tick();
    chk_irq(1'b0, "R8 mask zero irq low");
    rd(2'd1, 32'h1000, "R8 cause retained");
    wr(2'd2, 32'h1000);
    tick();
    chk_irq(1'b1, "R7 remask fires");
    wr(2'd1, 32'hFFFF_FFFF);
    tick();
    chk_irq(1'b0, "R4 clear all drops irq");
    rd(2'd1, 32'h0, "R4 clear all");

    // R5: rise collides with clear of same bit
    status_lvl = 13'h1071;
    tick();
    status_lvl = 13'h1051;
    tick();
    rd(2'd1, 32'h020, "R2 rx full cause");
    status_lvl = 13'h1071;
    wr(2'd1, 32'h020);
    rd(2'd1, 32'h020, "R5 rise beats clear");
    wr(2'd1, 32'h020);
    rd(2'd1, 32'h0, "R5 then cleared");

    // multi-bit pattern
    status_lvl = 13'h0000;
    tick(2);
    wr(2'd1, 32'hFFFF_FFFF);
    status_lvl = 13'h0F0F;
    tick();
    rd(2'd1, 32'h0F0F, "R2 multi-bit causes");
    rd(2'd0, 32'h0F0F, "R1 live multi-bit");
    wr(2'd1, 32'h0F00);
    rd(2'd1, 32'h000F, "R4 partial clear");

    // R6: dropped writes and empty address
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, 32'h1000, "R6 mask untouched");
    rd(2'd1, 32'h000F, "R6 cause untouched");
    rd(2'd3, 32'h0, "R6 empty address");
    rd(2'd0, 32'h0F0F, "R1 live view after writes");

    tick(3);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule